// File: doc/BRIEF.md
# Prioritized Range Translation Unit

This block translates CPU addresses through a small set of programmable regions. Each region covers a range of logical pages, given by a start page and a length in pages. It also holds a physical base page, a cache policy, a privilege level and a read-only flag. Each region keeps two statistics: a saturating hit counter and a written-to flag. The hit counter lets software choose which region to replace when it runs short of regions. The written-to flag lets software find which ranges, such as a screen buffer, were touched.

The CPU offers one access at a time: a logical address, a write flag and a supervisor flag. A small state machine moves through three states:
- **IDLE**: ready for a request. A valid request takes the transition *accept* into SEARCH.
- **SEARCH**: the priority matcher picks the lowest-numbered matching region, and the result is registered. The transition *resolve* always leads to REPLY.
- **REPLY**: the response is presented for exactly one cycle and the statistics of the winning region are updated. The transition *retire* always returns to IDLE.

Software loads a whole region in one write, which also resets that region's statistics. It reads a region's statistics through a separate index port.

Top module: `rng_mmu`

## Requirements
- R1: After reset every region is empty (zero length, access code 0), `req_ready` is 1, `rsp_valid` is 0, and every hit counter and written-to flag reads 0.
- R2: A request taken while `req_ready` is 1 gives `rsp_valid` high exactly two clock edges later, for exactly one cycle. `req_ready` is 0 from the edge after acceptance until the response has retired.
- R3: A region matches when the address page P satisfies start ≤ P < start + length, with pages being address bits above bit 11 (4 KB pages). The physical address is (base + P − start) in the page bits, with address bits 11:0 passed through unchanged.
- R4: When several regions match, the one with the lowest index decides the response.
- R5: An access that matches no region faults with cause 1. Every faulting response carries `rsp_fault`=1, `rsp_paddr`=0 and `rsp_cache`=2. Cause 0 means no fault.
- R6: The cache code is 0 for full caching, 1 for write-through and 2 for cache-inhibit. A region programmed with code 3 is reported as 2.
- R7: Access code 2 allows user and supervisor accesses. Code 1 allows supervisor only. Codes 0 and 3 allow nothing. A refused access faults with cause 2.
- R8: A write to a region with the read-only flag set, after the privilege check has passed, faults with cause 3. Reads of such a region succeed.
- R9: Every access decided by a region, faulting or not, adds one to that region's hit counter. The counter stops at 2^CNT_W−1 and never wraps.
- R10: A write decided by a region without a fault sets that region's written-to flag. Reads and faulting writes leave the flag unchanged.
- R11: A software load of a region clears its hit counter and its written-to flag. In a cycle where a load and a statistics update hit the same region, the load wins.
- R12: A region with length 0 matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Logical address |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor access |
| req_ready | output | 1 | Unit is idle and accepts a request |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | ADDR_W | Physical address (0 on fault) |
| rsp_cache | output | 2 | Cache policy code |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 no match, 2 privilege, 3 write-protect |
| cfg_we | input | 1 | Load a region |
| cfg_idx | input | IDX_W | Region to load |
| cfg_start | input | PG_W | Start page |
| cfg_len | input | PG_W | Length in pages |
| cfg_target | input | PG_W | Physical base page |
| cfg_cache | input | 2 | Cache policy code |
| cfg_acc | input | 2 | Access code |
| cfg_ro | input | 1 | Read-only flag |
| rd_idx | input | IDX_W | Region whose statistics are shown |
| rd_count | output | CNT_W | Hit counter of region `rd_idx` |
| rd_dirty | output | 1 | Written-to flag of region `rd_idx` |

## Verification
The stimulus uses overlapping regions, so the same address is sent once inside the higher-priority region and once only inside the lower one; this separates priority from plain matching. Addresses on the first and last page of a region, and one page past its end, separate a correct bound from an off-by-one bound. A single read-only, supervisor-only region is hit with a supervisor read, a user read and a supervisor write. This shows the order of the privilege and write-protect checks, and shows that faulting hits still count. A long run of hits on one region checks saturation, and a reload afterwards checks that the statistics clear.

// File: rtl/rng_mmu_pkg.sv
package rng_mmu_pkg;

    typedef enum logic [1:0] {
        CM_FULL    = 2'd0,
        CM_WTHRU   = 2'd1,
        CM_INHIBIT = 2'd2,
        CM_RSVD    = 2'd3
    } cache_mode_e;

    typedef enum logic [1:0] {
        AC_NONE  = 2'd0,
        AC_SUPER = 2'd1,
        AC_ALL   = 2'd2,
        AC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FC_OK    = 2'd0,
        FC_MISS  = 2'd1,
        FC_PRIV  = 2'd2,
        FC_WPROT = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_REPLY  = 2'd2
    } state_e;

endpackage

// File: rtl/rng_desc_bank.sv
module rng_desc_bank
    import rng_mmu_pkg::*;
#(
    parameter int N     = 16,
    parameter int PG_W  = 20,
    parameter int CNT_W = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic [PG_W-1:0]            cfg_start,
    input  logic [PG_W-1:0]            cfg_len,
    input  logic [PG_W-1:0]            cfg_target,
    input  logic [1:0]                 cfg_cache,
    input  logic [1:0]                 cfg_acc,
    input  logic                       cfg_ro,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           upd_idx,
    input  logic                       upd_dirty,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [N-1:0][PG_W-1:0]     d_start,
    output logic [N-1:0][PG_W-1:0]     d_len,
    output logic [N-1:0][PG_W-1:0]     d_target,
    output logic [N-1:0][1:0]          d_cache,
    output logic [N-1:0][1:0]          d_acc,
    output logic [N-1:0]               d_ro,
    output logic [CNT_W-1:0]           rd_count,
    output logic                       rd_dirty
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [N-1:0][CNT_W-1:0] cnt_arr;
    logic [N-1:0]            dirty_arr;

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [CNT_W-1:0] cnt;
        logic             dirty;
        logic             load;
        logic             touch;

        assign load  = cfg_we && (cfg_idx == MY_IDX);
        assign touch = upd_en && (upd_idx == MY_IDX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_start[i]  <= '0;
                d_len[i]    <= '0;
                d_target[i] <= '0;
                d_cache[i]  <= CM_INHIBIT;
                d_acc[i]    <= AC_NONE;
                d_ro[i]     <= 1'b0;
                cnt         <= '0;
                dirty       <= 1'b0;
            end else if (load) begin
                d_start[i]  <= cfg_start;
                d_len[i]    <= cfg_len;
                d_target[i] <= cfg_target;
                d_cache[i]  <= cfg_cache;
                d_acc[i]    <= cfg_acc;
                d_ro[i]     <= cfg_ro;
                cnt         <= '0;
                dirty       <= 1'b0;
            end else if (touch) begin
                if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
                if (upd_dirty) begin
                    dirty <= 1'b1;
                end
            end
        end

        assign cnt_arr[i]   = cnt;
        assign dirty_arr[i] = dirty;
    end

    assign rd_count = cnt_arr[rd_idx];
    assign rd_dirty = dirty_arr[rd_idx];

endmodule

// File: rtl/rng_matcher.sv
module rng_matcher #(
    parameter int N    = 16,
    parameter int PG_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [PG_W-1:0]        page,
    input  logic [N-1:0][PG_W-1:0] d_start,
    input  logic [N-1:0][PG_W-1:0] d_len,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx,
    output logic [PG_W-1:0]        offset
);

    logic [N-1:0]            in_rng;
    logic [N-1:0][PG_W-1:0]  off_arr;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign off_arr[i] = page - d_start[i];
        assign in_rng[i]  = (page >= d_start[i]) && (off_arr[i] < d_len[i]);
    end

    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        offset  = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (in_rng[j]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
                offset  = off_arr[j];
            end
        end
    end

endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
    import rng_mmu_pkg::*;
#(
    parameter int N     = 16,
    parameter int PG_W  = 20,
    parameter int OFF_W = 12,
    localparam int IDX_W = $clog2(N),
    localparam int AW    = PG_W + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_write,
    input  logic                    req_super,
    output logic                    req_ready,
    output logic [PG_W-1:0]         cap_page,
    input  logic                    m_hit,
    input  logic [IDX_W-1:0]        m_idx,
    input  logic [PG_W-1:0]         m_offset,
    input  logic [N-1:0][PG_W-1:0]  d_target,
    input  logic [N-1:0][1:0]       d_cache,
    input  logic [N-1:0][1:0]       d_acc,
    input  logic [N-1:0]            d_ro,
    output logic                    upd_en,
    output logic [IDX_W-1:0]        upd_idx,
    output logic                    upd_dirty,
    output logic                    rsp_valid,
    output logic [AW-1:0]           rsp_paddr,
    output logic [1:0]              rsp_cache,
    output logic                    rsp_fault,
    output logic [1:0]              rsp_cause
);

    state_e state, nxt;

    logic [OFF_W-1:0] cap_off;
    logic             cap_wr;
    logic             cap_sup;

    fault_e           cause_c;
    logic [AW-1:0]    paddr_c;
    logic [1:0]       cache_c;
    logic [1:0]       sel_acc;
    logic [1:0]       sel_cache;

    logic             hit_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_ok_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: accept, resolve, retire
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = req_valid ? ST_SEARCH : ST_IDLE;
            ST_SEARCH: nxt = ST_REPLY;
            ST_REPLY:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Request capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_page <= '0;
            cap_off  <= '0;
            cap_wr   <= 1'b0;
            cap_sup  <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            cap_page <= req_addr[AW-1:OFF_W];
            cap_off  <= req_addr[OFF_W-1:0];
            cap_wr   <= req_write;
            cap_sup  <= req_super;
        end
    end

    // Decision on the winning region
    always_comb begin
        sel_acc   = d_acc[m_idx];
        sel_cache = d_cache[m_idx];
        if (!m_hit) begin
            cause_c = FC_MISS;
        end else if (sel_acc == AC_NONE || sel_acc == AC_RSVD) begin
            cause_c = FC_PRIV;
        end else if (sel_acc == AC_SUPER && !cap_sup) begin
            cause_c = FC_PRIV;
        end else if (cap_wr && d_ro[m_idx]) begin
            cause_c = FC_WPROT;
        end else begin
            cause_c = FC_OK;
        end

        if (cause_c != FC_OK) begin
            paddr_c = '0;
            cache_c = CM_INHIBIT;
        end else begin
            paddr_c = {d_target[m_idx] + m_offset, cap_off};
            cache_c = (sel_cache == CM_RSVD) ? CM_INHIBIT : sel_cache;
        end
    end

    // Result register, loaded on resolve
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_cache <= CM_INHIBIT;
            rsp_fault <= 1'b0;
            rsp_cause <= FC_OK;
            hit_q     <= 1'b0;
            idx_q     <= '0;
            wr_ok_q   <= 1'b0;
        end else if (state == ST_SEARCH) begin
            rsp_paddr <= paddr_c;
            rsp_cache <= cache_c;
            rsp_fault <= (cause_c != FC_OK);
            rsp_cause <= cause_c;
            hit_q     <= m_hit;
            idx_q     <= m_idx;
            wr_ok_q   <= cap_wr && (cause_c == FC_OK);
        end
    end

    // Outputs by state
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_REPLY);
        upd_en    = (state == ST_REPLY) && hit_q;
        upd_idx   = idx_q;
        upd_dirty = wr_ok_q;
    end

endmodule

// File: rtl/rng_mmu.sv
module rng_mmu #(
    parameter int NUM_DESC   = 16,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = 4,
    localparam int PG_W  = ADDR_W - PAGE_SHIFT,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               req_super,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [1:0]         rsp_cache,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PG_W-1:0]    cfg_start,
    input  logic [PG_W-1:0]    cfg_len,
    input  logic [PG_W-1:0]    cfg_target,
    input  logic [1:0]         cfg_cache,
    input  logic [1:0]         cfg_acc,
    input  logic               cfg_ro,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CNT_W-1:0]   rd_count,
    output logic               rd_dirty
);

    logic [NUM_DESC-1:0][PG_W-1:0] d_start;
    logic [NUM_DESC-1:0][PG_W-1:0] d_len;
    logic [NUM_DESC-1:0][PG_W-1:0] d_target;
    logic [NUM_DESC-1:0][1:0]      d_cache;
    logic [NUM_DESC-1:0][1:0]      d_acc;
    logic [NUM_DESC-1:0]           d_ro;

    logic [PG_W-1:0]  cap_page;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [PG_W-1:0]  m_offset;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic             upd_dirty;

    rng_desc_bank #(.N(NUM_DESC), .PG_W(PG_W), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_start  (cfg_start),
        .cfg_len    (cfg_len),
        .cfg_target (cfg_target),
        .cfg_cache  (cfg_cache),
        .cfg_acc    (cfg_acc),
        .cfg_ro     (cfg_ro),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_dirty  (upd_dirty),
        .rd_idx     (rd_idx),
        .d_start    (d_start),
        .d_len      (d_len),
        .d_target   (d_target),
        .d_cache    (d_cache),
        .d_acc      (d_acc),
        .d_ro       (d_ro),
        .rd_count   (rd_count),
        .rd_dirty   (rd_dirty)
    );

    rng_matcher #(.N(NUM_DESC), .PG_W(PG_W)) u_match (
        .page    (cap_page),
        .d_start (d_start),
        .d_len   (d_len),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .offset  (m_offset)
    );

    rng_ctrl #(.N(NUM_DESC), .PG_W(PG_W), .OFF_W(PAGE_SHIFT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_super (req_super),
        .req_ready (req_ready),
        .cap_page  (cap_page),
        .m_hit     (m_hit),
        .m_idx     (m_idx),
        .m_offset  (m_offset),
        .d_target  (d_target),
        .d_cache   (d_cache),
        .d_acc     (d_acc),
        .d_ro      (d_ro),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_dirty (upd_dirty),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_cache (rsp_cache),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause)
    );

endmodule

// File: rtl/rng_mmu_chk.sv
module rng_mmu_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_cache,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [CNT_W-1:0]  rd_count,
    input logic              rd_dirty
);

    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    assert_busy_while_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_fault_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cache == 2'd2 && rsp_cause != 2'd0));

    assert_cache_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_cache != 2'd3));

    assert_count_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((rd_idx != $past(rd_idx)) || (rd_count >= $past(rd_count))));

    assert_dirty_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dirty && !cfg_we) |=> ((rd_idx != $past(rd_idx)) || rd_dirty));

    assert_load_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == rd_idx) |=> ((rd_idx != $past(rd_idx)) || (rd_count == '0 && !rd_dirty)));

endmodule

bind rng_mmu rng_mmu_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_cache (rsp_cache),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .rd_idx    (rd_idx),
    .rd_count  (rd_count),
    .rd_dirty  (rd_dirty)
);

// File: tb/rng_mmu_test.sv
module rng_mmu_test;

    localparam int NUM_DESC = 16;
    localparam int ADDR_W   = 32;
    localparam int PG_W     = 20;
    localparam int IDX_W    = 4;
    localparam int CNT_W    = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              req_write;
    logic              req_super;
    logic              req_ready;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_paddr;
    logic [1:0]        rsp_cache;
    logic              rsp_fault;
    logic [1:0]        rsp_cause;
    logic              cfg_we;
    logic [IDX_W-1:0]  cfg_idx;
    logic [PG_W-1:0]   cfg_start;
    logic [PG_W-1:0]   cfg_len;
    logic [PG_W-1:0]   cfg_target;
    logic [1:0]        cfg_cache;
    logic [1:0]        cfg_acc;
    logic              cfg_ro;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  rd_count;
    logic              rd_dirty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [ADDR_W-1:0] paddr;
        logic [1:0]        cache;
        logic              fault;
        logic [1:0]        cause;
        string             tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    rng_mmu #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .PAGE_SHIFT(12), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_super(req_super),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_cache(rsp_cache), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_start(cfg_start), .cfg_len(cfg_len),
        .cfg_target(cfg_target), .cfg_cache(cfg_cache), .cfg_acc(cfg_acc), .cfg_ro(cfg_ro),
        .rd_idx(rd_idx), .rd_count(rd_count), .rd_dirty(rd_dirty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected response", 64'(rsp_paddr), 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {27'd0, rsp_fault, rsp_cause, rsp_cache, rsp_paddr},
                           {27'd0, e.fault, e.cause, e.cache, e.paddr});
            end
        end
    end

    // Driver: one access, expected item pushed first
    task automatic issue(input logic [31:0] a, input logic w, input logic s,
                         input logic [31:0] ep, input logic [1:0] ec,
                         input logic [1:0] ecause, input string tag);
        exp_t e;
        e.paddr = ep; e.cache = ec; e.cause = ecause; e.fault = (ecause != 2'd0); e.tag = tag;
        @(negedge clk);
        exp_q.push_back(e);
        req_addr  = a;
        req_write = w;
        req_super = s;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 busy"}, 64'(req_ready), 64'd0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int idx, input logic [19:0] st, input logic [19:0] ln,
                        input logic [19:0] tg, input logic [1:0] cm, input logic [1:0] ac,
                        input logic ro);
        @(negedge clk);
        cfg_idx = IDX_W'(idx); cfg_start = st; cfg_len = ln; cfg_target = tg;
        cfg_cache = cm; cfg_acc = ac; cfg_ro = ro; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stats(input int idx, input int ecnt, input logic edirty, input string tag);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        #1;
        chk({tag, " count"}, 64'(rd_count), 64'(ecnt));
        chk({tag, " dirty"}, 64'(rd_dirty), 64'(edirty));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_super = 1'b0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_start = '0; cfg_len = '0; cfg_target = '0;
        cfg_cache = '0; cfg_acc = '0; cfg_ro = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 no response after reset", 64'(rsp_valid), 64'd0);
        stats(0, 0, 1'b0, "R1 stats after reset");
        issue(32'h0001_2345, 1'b0, 1'b1, 32'h0, 2'd2, 2'd1, "R1 empty table miss");
        stats(0, 0, 1'b0, "R1 miss leaves stats");

        load(0, 20'h00010, 20'd4,  20'h00200, 2'd1, 2'd2, 1'b0);
        load(1, 20'h00010, 20'd16, 20'h00800, 2'd0, 2'd2, 1'b0);
        load(2, 20'h00100, 20'd2,  20'h00040, 2'd3, 2'd1, 1'b1);
        load(3, 20'h00300, 20'd0,  20'h00900, 2'd0, 2'd2, 1'b0);
        load(4, 20'h00400, 20'd1,  20'h00A00, 2'd0, 2'd0, 1'b0);
        load(5, 20'h00500, 20'd1,  20'h00B00, 2'd0, 2'd3, 1'b0);

        // R3/R4: overlap, region 0 wins inside its pages
        issue(32'h0001_2345, 1'b0, 1'b0, 32'h0020_2345, 2'd1, 2'd0, "R4 lowest index wins");
        issue(32'h0001_5ABC, 1'b0, 1'b0, 32'h0080_5ABC, 2'd0, 2'd0, "R3 translate region 1");
        issue(32'h0001_3FFF, 1'b0, 1'b0, 32'h0020_3FFF, 2'd1, 2'd0, "R3 last page of region 0");
        issue(32'h0001_4000, 1'b0, 1'b0, 32'h0080_4000, 2'd0, 2'd0, "R3 one past region 0");
        issue(32'h0000_F000, 1'b0, 1'b0, 32'h0,         2'd2, 2'd1, "R5 below all regions");

        // R6/R7/R8 on region 2
        issue(32'h0010_0010, 1'b0, 1'b1, 32'h0004_0010, 2'd2, 2'd0, "R6 reserved cache as inhibit");
        issue(32'h0010_0010, 1'b0, 1'b0, 32'h0,         2'd2, 2'd2, "R7 user on supervisor region");
        issue(32'h0010_1008, 1'b1, 1'b1, 32'h0,         2'd2, 2'd3, "R8 write to read-only");
        stats(2, 3, 1'b0, "R9 R10 faulting hits count, no dirty");

        // R12, R7 codes 0 and 3
        issue(32'h0030_0000, 1'b0, 1'b1, 32'h0, 2'd2, 2'd1, "R12 zero length");
        issue(32'h0040_0000, 1'b0, 1'b1, 32'h0, 2'd2, 2'd2, "R7 access code 0");
        issue(32'h0050_0000, 1'b0, 1'b1, 32'h0, 2'd2, 2'd2, "R7 access code 3");

        // R10 write sets dirty
        issue(32'h0001_2000, 1'b1, 1'b0, 32'h0020_2000, 2'd1, 2'd0, "R10 write hit");
        stats(0, 3, 1'b1, "R10 region 0 after write");
        stats(1, 2, 1'b0, "R10 region 1 reads only");

        // R9 saturation
        for (int k = 0; k < 18; k++) begin
            issue(32'h0001_F001, 1'b0, 1'b0, 32'h0080_F001, 2'd0, 2'd0, "R3 region 1 top page");
        end
        stats(1, 15, 1'b0, "R9 saturated counter");

        // R11 reload clears
        load(1, 20'h00010, 20'd16, 20'h00800, 2'd0, 2'd2, 1'b0);
        stats(1, 0, 1'b0, "R11 reload region 1");
        load(0, 20'h00010, 20'd4, 20'h00200, 2'd1, 2'd2, 1'b0);
        stats(0, 0, 1'b0, "R11 reload region 0");
        issue(32'h0001_F001, 1'b0, 1'b0, 32'h0080_F001, 2'd0, 2'd0, "R9 count after reload");
        stats(1, 1, 1'b0, "R9 count restarts");

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule